// File: doc/BRIEF.md
# Four-Lane 7:1 Serializing Transmitter

This block turns a 28-bit parallel word, presented once per input clock period, into four serial lanes. Each lane carries a 7-bit slice of the word per input period. A fifth lane carries a forwarded clock, sent as a fixed 7-bit pattern in step with the data lanes. The receiver uses that pattern both as a frequency reference and to find where each frame starts.

The word is registered on either the rising or the falling edge of the input clock, chosen by a select input. It is then handed to the bit-clock domain through a holding register. The bit clock is phase-locked and runs at seven times the input rate; it is generated outside this block. A mod-7 slot counter reloads the lane shift registers once per frame.

An active-low shutdown input clears every register in both clock domains and holds all serial outputs low. On release, framing restarts from slot 0. The forwarded clock stays low until a word captured after the release has reached the shift registers.

Top module: `ser7_tx`

## Requirements
- R1: With `edge_sel` = 0 the word is captured on the rising edge of `clk_in`. With `edge_sel` = 1 it is captured on the falling edge.
- R2: Lane k carries word bits 7k+6 down to 7k, highest bit first, so bit 7k+6 is the first bit of the frame.
- R3: The forwarded clock lane sends 1,1,0,0,0,1,1 in every frame, aligned with the data frames. The first bit of each frame is high and the fourth bit is low.
- R4: The slot counter stays within 0..6 and returns to 0 after slot 6. The shift registers reload once every 7 bit-clock cycles.
- R5: Captured words leave in capture order, one frame per input clock period, with none lost or repeated.
- R6: While `shutdown_n` is low, every register is cleared and all serial outputs are low from the next `clk_bit` edge onward.
- R7: After `shutdown_n` rises, the slot counter starts at 0. The forwarded clock lane first goes high 14 bit periods after the release, with the default hold slot and with the release placed just after a capture edge. The first framed word is the first word captured after the release.
- R8: The holding register changes only in the hold slot (slot 3 by default), once per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input (word) clock |
| shutdown_n | input | 1 | Active-low shutdown and clear |
| edge_sel | input | 1 | Capture edge: 0 rising, 1 falling |
| data_in | input | 28 | Parallel word |
| clk_bit | input | 1 | Phase-locked bit clock, 7x `clk_in` |
| lane_out | output | 4 | Serial data lanes, lane k at bit k |
| clk_lane_out | output | 1 | Serial forwarded clock lane |

## Verification
The bench drives four families of words: a walking one, all ones, alternating bits, and a multiplicative scramble. It deserializes every lane, using the clock pattern to find frame alignment. The walking one exposes a swapped lane, a reversed bit order or a shifted slice, since only one position may be set. The alternating and scrambled words expose a dropped or repeated frame in the ordered comparison. Running the same stream in both edge modes distinguishes the two capture edges, because data changes on the opposite edge. A shutdown in the middle of a stream, followed by a restart, checks the idle outputs, the restart latency, and that no stale word is framed.

// File: rtl/ser7_pkg.sv
package ser7_pkg;

  // Forwarded clock pattern in send order (MSB first): high for the first and
  // last quarter of the frame, rounded up, low in between.
  function automatic logic [63:0] frame_clock_pattern(input int n);
    logic [63:0] p;
    int          edge_w;
    p      = '0;
    edge_w = (n + 1) / 4;
    for (int pos = 0; pos < n; pos++) begin
      if (pos < edge_w || pos >= n - edge_w) p[n-1-pos] = 1'b1;
    end
    return p;
  endfunction

endpackage

// File: rtl/ser7_capture.sv
module ser7_capture #(
  parameter int WORD = 28
) (
  input  logic            clk_in,
  input  logic            shutdown_n,
  input  logic            edge_sel,
  input  logic [WORD-1:0] data_in,
  output logic [WORD-1:0] cap_word,
  output logic            cap_seen
);
  logic [WORD-1:0] rise_q, fall_q;
  logic            rise_seen, fall_seen;

  always_ff @(posedge clk_in) begin
    if (!shutdown_n) begin
      rise_q    <= '0;
      rise_seen <= 1'b0;
    end else begin
      rise_q    <= data_in;
      rise_seen <= 1'b1;
    end
  end

  always_ff @(negedge clk_in) begin
    if (!shutdown_n) begin
      fall_q    <= '0;
      fall_seen <= 1'b0;
    end else begin
      fall_q    <= data_in;
      fall_seen <= 1'b1;
    end
  end

  assign cap_word = edge_sel ? fall_q : rise_q;
  assign cap_seen = edge_sel ? fall_seen : rise_seen;
endmodule

// File: rtl/ser7_slot.sv
module ser7_slot #(
  parameter int SLICE = 7,
  parameter int SW    = 3
) (
  input  logic          clk_bit,
  input  logic          shutdown_n,
  output logic [SW-1:0] slot,
  output logic          load
);
  localparam logic [SW-1:0] LAST = SW'(SLICE - 1);

  always_ff @(posedge clk_bit) begin
    if (!shutdown_n)       slot <= '0;
    else if (slot == LAST) slot <= '0;
    else                   slot <= slot + 1'b1;
  end

  assign load = (slot == LAST);

  a_r4_slot_range: assert property (@(posedge clk_bit) disable iff (!shutdown_n)
    slot <= LAST);
  a_r4_slot_wrap: assert property (@(posedge clk_bit) disable iff (!shutdown_n)
    (slot == LAST) |=> (slot == '0));
endmodule

// File: rtl/ser7_hold.sv
module ser7_hold #(
  parameter int WORD      = 28,
  parameter int SW        = 3,
  parameter int HOLD_SLOT = 3
) (
  input  logic            clk_bit,
  input  logic            shutdown_n,
  input  logic [SW-1:0]   slot,
  input  logic [WORD-1:0] cap_word,
  input  logic            cap_seen,
  output logic [WORD-1:0] hold_word,
  output logic            primed
);
  localparam logic [SW-1:0] TAKE = SW'(HOLD_SLOT);

  always_ff @(posedge clk_bit) begin
    if (!shutdown_n) begin
      hold_word <= '0;
      primed    <= 1'b0;
    end else if (slot == TAKE) begin
      hold_word <= cap_word;
      primed    <= primed | cap_seen;
    end
  end

  a_r8_hold_once: assert property (@(posedge clk_bit) disable iff (!shutdown_n)
    (slot != TAKE) |=> $stable(hold_word));
endmodule

// File: rtl/ser7_shift.sv
module ser7_shift #(
  parameter int SLICE = 7
) (
  input  logic             clk_bit,
  input  logic             shutdown_n,
  input  logic             load,
  input  logic [SLICE-1:0] par,
  output logic             ser
);
  logic [SLICE-1:0] sr;

  always_ff @(posedge clk_bit) begin
    if (!shutdown_n) sr <= '0;
    else if (load)   sr <= par;
    else             sr <= {sr[SLICE-2:0], 1'b0};
  end

  assign ser = sr[SLICE-1];
endmodule

// File: rtl/ser7_tx.sv
module ser7_tx
  import ser7_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int SLICE     = 7,
  parameter int HOLD_SLOT = 3
) (
  input  logic                   clk_in,
  input  logic                   shutdown_n,
  input  logic                   edge_sel,
  input  logic [LANES*SLICE-1:0] data_in,
  input  logic                   clk_bit,
  output logic [LANES-1:0]       lane_out,
  output logic                   clk_lane_out
);
  localparam int               WORD    = LANES * SLICE;
  localparam int               SW      = (SLICE > 1) ? $clog2(SLICE) : 1;
  localparam logic [63:0]      PAT_ALL = frame_clock_pattern(SLICE);
  localparam logic [SLICE-1:0] CLK_PAT = PAT_ALL[SLICE-1:0];
  localparam logic [SW-1:0]    MID     = SW'(SLICE / 2);

  logic [WORD-1:0]  cap_word, hold_word;
  logic             cap_seen, primed, load;
  logic [SW-1:0]    slot;
  logic [SLICE-1:0] clk_par;

  ser7_capture #(.WORD(WORD)) u_cap (
    .clk_in(clk_in), .shutdown_n(shutdown_n), .edge_sel(edge_sel),
    .data_in(data_in), .cap_word(cap_word), .cap_seen(cap_seen));

  ser7_slot #(.SLICE(SLICE), .SW(SW)) u_slot (
    .clk_bit(clk_bit), .shutdown_n(shutdown_n), .slot(slot), .load(load));

  ser7_hold #(.WORD(WORD), .SW(SW), .HOLD_SLOT(HOLD_SLOT)) u_hold (
    .clk_bit(clk_bit), .shutdown_n(shutdown_n), .slot(slot),
    .cap_word(cap_word), .cap_seen(cap_seen),
    .hold_word(hold_word), .primed(primed));

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      ser7_shift #(.SLICE(SLICE)) u_sh (
        .clk_bit(clk_bit), .shutdown_n(shutdown_n), .load(load),
        .par(hold_word[k*SLICE +: SLICE]), .ser(lane_out[k]));
    end
  endgenerate

  assign clk_par = primed ? CLK_PAT : '0;

  ser7_shift #(.SLICE(SLICE)) u_clk (
    .clk_bit(clk_bit), .shutdown_n(shutdown_n), .load(load),
    .par(clk_par), .ser(clk_lane_out));

  // R3: first bit of each frame follows the primed state, middle bit is low.
  a_r3_frame_head: assert property (@(posedge clk_bit) disable iff (!shutdown_n)
    (slot == '0) |-> (clk_lane_out == primed));
  a_r3_frame_mid: assert property (@(posedge clk_bit) disable iff (!shutdown_n)
    (slot == MID) |-> !clk_lane_out);
  // R7: release starts framing from slot 0 with nothing transferred.
  a_r7_restart: assert property (@(posedge clk_bit) disable iff (!shutdown_n)
    $rose(shutdown_n) |-> (slot == '0 && !primed));

  // R6: one edge after shutdown was seen low, every output is low.
  logic down_d;
  always_ff @(posedge clk_bit) begin
    if (down_d) begin
      a_r6_idle: assert ({lane_out, clk_lane_out} == '0)
        else $error("R6 outputs not idle in shutdown");
    end
    down_d <= !shutdown_n;
  end
endmodule

// File: tb/ser7_tx_test.sv
module ser7_tx_test;
  localparam int LANES = 4;
  localparam int SLICE = 7;
  localparam int WORD  = LANES * SLICE;
  localparam logic [6:0] PAT = 7'b1100011;

  logic            clk_bit = 1'b0;
  logic            clk_in  = 1'b0;
  logic            shutdown_n = 1'b0;
  logic            edge_sel   = 1'b0;
  logic [WORD-1:0] data_in    = '0;
  logic [LANES-1:0] lane_out;
  logic            clk_lane_out;

  int n_checks = 0;
  int n_fail   = 0;
  int ph       = 0;
  logic [WORD-1:0] exp_q[$];

  ser7_tx uut (
    .clk_in(clk_in), .shutdown_n(shutdown_n), .edge_sel(edge_sel),
    .data_in(data_in), .clk_bit(clk_bit),
    .lane_out(lane_out), .clk_lane_out(clk_lane_out));

  always #4 clk_bit = ~clk_bit;   // 125 MHz bit clock

  // Word clock: 7 bit periods, edges on bit-clock falling edges.
  always @(negedge clk_bit) begin
    ph     = (ph == 6) ? 0 : ph + 1;
    clk_in = (ph < 4);
  end

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WORD-1:0] pattern(input int fam, input int i);
    logic [31:0] m;
    case (fam % 4)
      0: return WORD'(1) << (i % WORD);
      1: return (i % 2) ? '1 : '0;
      2: return (i % 2) ? WORD'(28'hAAAAAAA) : WORD'(28'h5555555);
      default: begin m = (i + 1) * 32'h9E3779B1; return m[WORD-1:0]; end
    endcase
  endfunction

  // Monitor: deserialize using the forwarded clock pattern for alignment.
  logic [6:0] win [LANES];
  logic [6:0] cwin = '0;
  bit locked = 0;
  int bitcnt = 0;
  always @(negedge clk_bit) begin
    logic frame;
    logic [WORD-1:0] got, exp;
    frame = 0;
    for (int k = 0; k < LANES; k++) win[k] = {win[k][5:0], lane_out[k]};
    cwin = {cwin[5:0], clk_lane_out};
    if (!shutdown_n) begin
      locked = 0;
    end else if (locked) begin
      bitcnt++;
      if (bitcnt == 7) begin
        bitcnt = 0;
        frame  = 1;
        check(cwin == PAT, "R3 clock lane pattern", 32'(cwin), 32'(PAT));
      end
    end else if (cwin == PAT) begin
      locked = 1;
      bitcnt = 0;
      frame  = 1;
    end
    if (frame && exp_q.size() > 0) begin
      for (int k = 0; k < LANES; k++) got[k*SLICE +: SLICE] = win[k];
      exp = exp_q.pop_front();
      check(got == exp, "R1/R2/R5 word", 32'(got), 32'(exp));
    end
  end

  task automatic release_dut();
    if (edge_sel) @(negedge clk_in); else @(posedge clk_in);
    #1 shutdown_n = 1'b1;
    fork
      begin
        int n;
        bit seen;
        n = 0; seen = 0;
        for (int i = 1; i <= 40 && !seen; i++) begin
          @(negedge clk_bit);
          if (clk_lane_out) begin seen = 1; n = i; end
        end
        check(n == 14, "R7 first clock-lane high", 32'(n), 32'd14);
      end
    join_none
  endtask

  // Driver: change data on the non-capturing edge, queue expected word.
  task automatic stream(input int fam, input int count);
    for (int i = 0; i < count; i++) begin
      if (edge_sel) @(posedge clk_in); else @(negedge clk_in);
      #1;
      data_in = pattern(fam + i / 6, i);
      exp_q.push_back(data_in);
    end
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (20) @(negedge clk_bit);
    check(exp_q.size() == 0, "R5 queue drained", 32'(exp_q.size()), 32'd0);
  endtask

  task automatic go_idle();
    @(negedge clk_bit);
    #1 shutdown_n = 1'b0;
    repeat (2) @(negedge clk_bit);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk_bit);
      check({lane_out, clk_lane_out} == '0, "R6 idle in shutdown",
            32'({lane_out, clk_lane_out}), 32'd0);
    end
  endtask

  initial begin
    for (int k = 0; k < LANES; k++) win[k] = '0;
    repeat (20) @(negedge clk_bit);
    check({lane_out, clk_lane_out} == '0, "R6 reset state",
          32'({lane_out, clk_lane_out}), 32'd0);
    // R1 rising-edge capture, all pattern families (R2, R3, R4, R5)
    edge_sel = 1'b0;
    release_dut();
    stream(0, 24);
    drain();
    go_idle();
    // R1 falling-edge capture
    edge_sel = 1'b1;
    release_dut();
    stream(1, 24);
    drain();
    go_idle();
    // R7 shutdown mid-stream, then restart
    edge_sel = 1'b0;
    release_dut();
    stream(3, 8);
    go_idle();
    exp_q.delete();
    release_dut();
    stream(2, 12);
    drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_bit);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule